// File: doc/BRIEF.md
# Reload-Period PWM Timer with Triggered Single Pulse

This block is a four-channel pulse-width modulator built around one shared 12-bit up-counter. The counter starts at a reload value that software writes and counts up by one each clock. When it passes its all-ones value it takes the reload value again. The reload value therefore sets the period, which is 4096 minus the reload value. Each channel compares the counter with its own duty value and drives a level from that comparison. A polarity bit can invert that level. An enable bit gives the channel its pin, and a separate pin-ownership output tells the pad multiplexer which source to select. Each channel also latches a compare flag when the counter meets its duty value.

Channels 2 and 3 can also run in a single-pulse mode. A control bit in channel 3's status register turns this mode on, and a second bit there selects which edge of the trigger input starts a pulse. In this mode the counter waits at rest. A synchronized edge of the selected kind reloads it and runs exactly one period, and then the counter halts again. Software reaches all settings through a byte-wide register port with separate write and read strobes. Reading a channel's status register clears that channel's compare flag.

Top module: `apwm_timer`

## Requirements
- R1: Address 0 holds the low byte of the 12-bit reload value and address 1 holds its upper four bits in bits 3:0. Bits 7:4 of address 1 always read as zero. After reset, every register reads 00h.
- R2: While the counter runs, it steps by one each cycle up to FFFh. On the following cycle it holds the reload value, so one period lasts 4096 minus the reload value cycles.
- R3: A channel's level is high while the counter is below that channel's active duty value. Over one period the level is high for the duty value minus the reload value cycles, or for zero cycles when the duty value does not exceed the reload value.
- R4: A write to a duty register (channel c at address 8+2c for the low byte and 9+2c for bits 11:8) only changes a pending copy. The active duty value takes the pending copy when the counter wraps or when a single pulse starts.
- R5: Address 2 bits 3:0 enable channels 0 to 3. An enabled channel drives pwm_out, and a disabled channel holds pwm_out low. pwm_oe always shows the enable bits.
- R6: In channel c's status register at address 4+c, bit 1 inverts that channel's output level.
- R7: Bit 0 of a status register is the compare flag. It is set on a cycle where the counter is running and equals the active duty value. A read strobe on that status address clears it, and reads of any other address leave it unchanged. If a set and a clear fall on the same cycle, the set takes effect.
- R8: Bit 3 (single-pulse enable) and bit 2 (edge select: 1 for rising, 0 for falling) exist only at address 7. Those bits read as zero in the other three status registers.
- R9: While single-pulse mode is on, the counter stays still until the selected trigger edge arrives. That edge passes through a two-flop synchronizer. It reloads the counter and runs one period, and then the counter halts at the reload value. Channels 2 and 3 keep their level low while the counter is halted, and edges that arrive during a pulse are ignored.
- R10: An edge of the kind that is not selected starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, clears a compare flag when it addresses a status register |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| trig_in | input | 1 | Asynchronous trigger for single-pulse mode |
| pwm_out | output | 4 | Channel outputs, low when disabled |
| pwm_oe | output | 4 | Pin-ownership signals for the pad multiplexer |

## Verification
The hardest case to reach from the ports is a compare flag whose state the bench knows exactly. While the counter runs freely, a match can happen between any two reads, so a flag read from the ports is ambiguous. The stimulus therefore switches to single-pulse mode, where the counter stays halted. It clears the flags by reading them and fires exactly one triggered period. It then reads the flag twice to see it set and then cleared, and reads another address in between to show that such a read does not disturb the flag. Randomized periods and duties are checked by counting high cycles over a whole number of periods, and that count does not depend on the phase at which the window starts.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 4;
  localparam int OP_CH  = 3;          // channel whose status register holds the single-pulse bits
  localparam int HI_W   = CNT_W - DATA_W;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam cnt_t CNT_MAX = '1;

  localparam logic [ADDR_W-1:0] A_RLD_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_OE     = 4'h2;

  // level before polarity: high while the count is below the duty value
  function automatic logic pwm_level(input cnt_t count, input cnt_t duty);
    return count < duty;
  endfunction

  function automatic logic cmp_hit(input cnt_t count, input cnt_t duty);
    return count == duty;
  endfunction

  function automatic logic pick_edge(input logic rise, input logic fall, input logic sel_rise);
    return sel_rise ? rise : fall;
  endfunction

  function automatic byte_t hi_byte(input cnt_t v);
    return {{(DATA_W-HI_W){1'b0}}, v[CNT_W-1:DATA_W]};
  endfunction
endpackage

// File: rtl/apwm_trig_sync.sv
module apwm_trig_sync
  import apwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic sel_rise,
  output logic edge_hit
);
  logic meta_q, sync_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= trig_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise     = sync_q & ~prev_q;
  assign fall     = ~sync_q & prev_q;
  assign edge_hit = pick_edge(rise, fall, sel_rise);

  // R9
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && $stable(sel_rise)) |=> !edge_hit);
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter
  import apwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t reload,
  input  logic op_en,
  input  logic trig_hit,
  output cnt_t cnt,
  output logic tick,
  output logic ovf,
  output logic start,
  output logic running
);
  cnt_t cnt_q;
  logic run_q;

  assign tick    = !op_en || run_q;
  assign start   = op_en && !run_q && trig_hit;
  assign ovf     = tick && (cnt_q == CNT_MAX);
  assign cnt     = cnt_q;
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (start || ovf)  cnt_q <= reload;
      else if (tick)     cnt_q <= cnt_q + 1'b1;

      if (!op_en)        run_q <= 1'b0;
      else if (start)    run_q <= 1'b1;
      else if (ovf)      run_q <= 1'b0;
    end
  end

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == $past(reload));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf && !start) |=> cnt == $past(cnt) + 1'b1);
  // R9
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !running && !start) |=> $stable(cnt));
  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && ovf) |=> !running);
endmodule

// File: rtl/apwm_channel.sv
module apwm_channel
  import apwm_pkg::*;
#(
  parameter bit GATED = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  logic  wr_csr,
  input  byte_t wdata,
  input  logic  rd_csr,
  input  cnt_t  cnt,
  input  logic  tick,
  input  logic  load,
  input  logic  running,
  input  logic  op_en,
  input  logic  oe,
  output logic  pwm,
  output logic  flag,
  output logic  pol,
  output cnt_t  duty_pre
);
  cnt_t pre_q, act_q;
  logic pol_q, flag_q;
  logic hit, lvl, idle, raw;

  assign hit  = tick && cmp_hit(cnt, act_q);
  assign lvl  = pwm_level(cnt, act_q);
  assign idle = GATED && op_en && !running;
  assign raw  = idle ? 1'b0 : lvl;
  assign pwm  = oe && (raw ^ pol_q);

  assign flag     = flag_q;
  assign pol      = pol_q;
  assign duty_pre = pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      act_q  <= '0;
      pol_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lo) pre_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) pre_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (load)  act_q <= pre_q;
      if (wr_csr) pol_q <= wdata[1];
      if (hit)         flag_q <= 1'b1;
      else if (rd_csr) flag_q <= 1'b0;
    end
  end

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_csr && !hit) |=> !flag);
endmodule

// File: rtl/apwm_timer.sv
module apwm_timer
  import apwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trig_in,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  cnt_t              reload_q;
  logic [NUM_CH-1:0] oe_q;
  logic              op_en_q, op_rise_q;

  cnt_t              cnt;
  logic              tick, ovf, start, running, edge_hit;
  logic [NUM_CH-1:0] flag, pol;
  cnt_t              duty_pre [NUM_CH];

  logic is_csr, is_duty;
  logic [1:0] csr_ch, duty_ch;

  assign is_csr  = bus_addr[3:2] == 2'b01;
  assign is_duty = bus_addr[3];
  assign csr_ch  = bus_addr[1:0];
  assign duty_ch = bus_addr[2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= '0;
      oe_q      <= '0;
      op_en_q   <= 1'b0;
      op_rise_q <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_RLD_LO) reload_q[DATA_W-1:0]     <= bus_wdata;
      if (bus_addr == A_RLD_HI) reload_q[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
      if (bus_addr == A_OE)     oe_q <= bus_wdata[NUM_CH-1:0];
      if (is_csr && csr_ch == 2'(OP_CH)) begin
        op_en_q   <= bus_wdata[3];
        op_rise_q <= bus_wdata[2];
      end
    end
  end

  apwm_trig_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .sel_rise (op_rise_q),
    .edge_hit (edge_hit)
  );

  apwm_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload_q),
    .op_en    (op_en_q),
    .trig_hit (edge_hit),
    .cnt      (cnt),
    .tick     (tick),
    .ovf      (ovf),
    .start    (start),
    .running  (running)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_lo, wr_hi, wr_csr, rd_csr;
    assign wr_lo  = bus_we && is_duty && duty_ch == 2'(c) && !bus_addr[0];
    assign wr_hi  = bus_we && is_duty && duty_ch == 2'(c) &&  bus_addr[0];
    assign wr_csr = bus_we && is_csr  && csr_ch  == 2'(c);
    assign rd_csr = bus_re && is_csr  && csr_ch  == 2'(c);

    apwm_channel #(.GATED(c >= 2)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wr_csr   (wr_csr),
      .wdata    (bus_wdata),
      .rd_csr   (rd_csr),
      .cnt      (cnt),
      .tick     (tick),
      .load     (ovf || start),
      .running  (running),
      .op_en    (op_en_q),
      .oe       (oe_q[c]),
      .pwm      (pwm_out[c]),
      .flag     (flag[c]),
      .pol      (pol[c]),
      .duty_pre (duty_pre[c])
    );
  end

  assign pwm_oe = oe_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RLD_LO)      bus_rdata = reload_q[DATA_W-1:0];
    else if (bus_addr == A_RLD_HI) bus_rdata = hi_byte(reload_q);
    else if (bus_addr == A_OE)     bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, oe_q};
    else if (is_csr) begin
      bus_rdata[1] = pol[csr_ch];
      bus_rdata[0] = flag[csr_ch];
      if (csr_ch == 2'(OP_CH)) begin
        bus_rdata[3] = op_en_q;
        bus_rdata[2] = op_rise_q;
      end
    end else if (is_duty) begin
      bus_rdata = bus_addr[0] ? hi_byte(duty_pre[duty_ch]) : duty_pre[duty_ch][DATA_W-1:0];
    end
  end

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_oe[0]) |-> !pwm_out[0]);
endmodule

// File: tb/apwm_timer_test.sv
`timescale 1ns/1ps
module apwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       trig_in = 1'b0;
  logic [3:0] pwm_out, pwm_oe;

  int tests = 0;
  int fails = 0;
  int hc [4];
  bit done = 1'b0;

  always #4 clk = ~clk;

  apwm_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic count_hi(input int n);
    for (int i = 0; i < 4; i++) hc[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (pwm_out[i]) hc[i]++;
    end
  endtask

  task automatic set_duty(input int ch, input logic [11:0] d);
    wr(4'(8 + 2*ch), d[7:0]);
    wr(4'(9 + 2*ch), {4'h0, d[11:8]});
  endtask

  // high cycles per period, from the level rule and the reload period
  function automatic int high_per(input int rl, input int duty, input bit p, input bit en);
    int per = 4096 - rl;
    int h = (duty > rl) ? duty - rl : 0;
    if (!en) return 0;
    return p ? per - h : h;
  endfunction

  initial begin
    logic [7:0] r;
    int rl, per;
    int dt [4];
    bit pl [4], en [4];
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    #1;
    check("R1 reset reload lo", int'(bus_rdata), 0);
    check("R5 reset pwm_out", int'(pwm_out), 0);
    check("R5 reset pwm_oe", int'(pwm_oe), 0);
    rd(4'h2, r); check("R1 reset oe reg", int'(r), 0);
    rd(4'h7, r); check("R1 reset csr3 ctrl", int'(r & 8'hFE), 0);
    rd(4'h8, r); check("R1 reset duty0", int'(r), 0);

    // reserved nibble
    wr(4'h1, 8'hFF); rd(4'h1, r); check("R1 reload hi masked", int'(r), 8'h0F);
    wr(4'hB, 8'hA5); rd(4'hB, r); check("R4 duty hi masked", int'(r), 8'h05);

    // randomized periods, duties, polarity and enables
    for (int t = 0; t < 8; t++) begin
      rl = 12'hF00 + int'($urandom % 240);
      per = 4096 - rl;
      wr(4'h0, 8'(rl)); wr(4'h1, 8'(rl >> 8));
      for (int c = 0; c < 4; c++) begin
        dt[c] = 12'hF00 + int'($urandom % 256);
        if (t == 0 && c == 0) dt[c] = 12'hFFF;
        if (t == 1 && c == 1) dt[c] = rl;
        pl[c] = 1'($urandom);
        en[c] = (t == 0) ? 1'b1 : 1'($urandom);
        set_duty(c, 12'(dt[c]));
        wr(4'(4 + c), {6'h0, pl[c], 1'b0});
      end
      wr(4'h2, {4'h0, en[3], en[2], en[1], en[0]});
      #1;
      check("R5 pwm_oe mirrors enables", int'(pwm_oe), int'({en[3], en[2], en[1], en[0]}));
      repeat (4096 + 2*per) @(negedge clk);
      count_hi(2*per);
      for (int c = 0; c < 4; c++)
        check($sformatf("R2 R3 R6 R5 ch%0d trial%0d high count", c, t), hc[c],
              2*high_per(rl, dt[c], pl[c], en[c]));
    end

    // single-pulse setup: period 16, ch2 high 8, ch3 high 4
    wr(4'h0, 8'hF0); wr(4'h1, 8'h0F);
    for (int c = 0; c < 4; c++) wr(4'(4 + c), 8'h00);
    set_duty(2, 12'hFF8);
    set_duty(3, 12'hFF4);
    wr(4'h2, 8'h0F);
    repeat (4200) @(negedge clk);

    wr(4'h4, 8'h0C); rd(4'h4, r); check("R8 csr0 has no pulse bits", int'(r & 8'hFC), 0);
    wr(4'h7, 8'h0C); rd(4'h7, r); check("R8 csr3 pulse bits", int'(r & 8'hFE), 8'h0C);
    repeat (20) @(negedge clk);
    rd(4'h6, r); rd(4'h7, r);
    count_hi(40);
    check("R9 ch2 idle low", hc[2], 0);
    check("R9 ch3 idle low", hc[3], 0);
    rd(4'h6, r); check("R7 flag quiet while halted", int'(r & 8'h01), 0);

    trig_in = 1'b1;
    count_hi(60);
    check("R9 ch2 one pulse", hc[2], 8);
    check("R9 ch3 one pulse", hc[3], 4);
    rd(4'h6, r); check("R7 flag set by pulse", int'(r & 8'h01), 1);
    rd(4'h6, r); check("R7 flag cleared by read", int'(r & 8'h01), 0);

    trig_in = 1'b0;
    count_hi(60);
    check("R10 falling ignored in rising mode", hc[2], 0);

    // R4: new duty taken at pulse start
    set_duty(2, 12'hFFC);
    wr(4'h7, 8'h08);
    trig_in = 1'b1;
    count_hi(60);
    check("R10 rising ignored in falling mode", hc[2], 0);
    trig_in = 1'b0;
    count_hi(60);
    check("R4 R9 pulse uses new duty", hc[2], 12);
    rd(4'h2, r); rd(4'h5, r);
    rd(4'h7, r); check("R7 flag kept across other reads", int'(r & 8'h01), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule